// File: doc/BRIEF.md
# Watch Mode Power Sequencer

This block sequences a small controller in and out of a low-power watch state. When software issues a sleep request, the block checks three configuration bits and the current operating mode. It then either enters watch or ignores the request. While in watch, the CPU and peripheral clock enables are dropped and a hold signal freezes register, RAM and pin state. Only the watchdog clock keeps running.

An enabled wake event ends watch. The event can be a non-maskable interrupt, one of five external interrupt lines, or the watchdog overflow interrupt. A low-speed select bit and a medium-speed select bit choose the target mode. Subactive and medium-speed are entered at once. High-speed is entered only after an oscillator settling delay, whose length comes from a 3-bit code. Once the target mode is entered, a one-cycle exception-start pulse is issued together with a code naming the wake source.

A low level on the hardware-standby pin overrides everything, including reset. It shuts every clock off until reset is applied with the pin high.

Top module: `watch_pwr_ctrl`

## Requirements
- R1: While `rst` is high and `stby_n` is high, the next clock edge gives `mode_o`=0 (high-speed), CPU, peripheral and watchdog enables all 1, `hold_o`=0 and `exc_start`=0.
- R2: A `sleep_req` sampled while `mode_o` is 0 (high-speed) or 2 (subactive), with `cfg_ssby`=1, `cfg_dton`=0 and `cfg_pss`=1, puts `mode_o` at 3 (watch) after that edge.
- R3: A `sleep_req` under any other combination of these bits or modes is ignored, including in mode 1 (medium-speed), and `mode_o` keeps its value.
- R4: In watch, `cpu_clk_en`=0, `per_clk_en`=0, `wdt_clk_en`=1 and `hold_o`=1.
- R5: In watch, `nmi` always wakes the block. Bit i of `irq` wakes it only when bit i of `irq_en` is 1. `wdt_ovf` wakes it only when `wdt_ovf_en`=1 and `wdt_mask`=0.
- R6: A wake with `cfg_lson`=1 goes to mode 2 on the wake edge. A wake with `cfg_lson`=0 and `cfg_med`=1 goes to mode 1 on the wake edge. In both cases `exc_start`=1 on that same edge.
- R7: A wake with `cfg_lson`=0 and `cfg_med`=0 gives mode 4 (settling) for exactly 2^(8+`cfg_sts`) cycles, with `hold_o`=1 and CPU and peripheral enables 0. Mode 0 follows, together with `exc_start`=1.
- R8: The settling length uses `cfg_sts` as sampled on the wake edge. Later changes have no effect on it.
- R9: `exc_start` is a one-cycle pulse, issued once per wake. `exc_src` gives the source: 1 for NMI, 2 for an external line, 3 for the watchdog. When several sources fire in the same cycle, the priority is NMI, then external line, then watchdog.
- R10: `stby_n`=0 forces `mode_o`=5 (hardware standby) from any mode, even with `rst` high, and all three clock enables go to 0. Mode 5 is left only through `rst` with `stby_n` high.
- R11: `rst` takes precedence over a same-cycle wake. The result is mode 0 with no `exc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| stby_n | input | 1 | Hardware-standby pin, active low |
| sleep_req | input | 1 | Sleep instruction strobe |
| cfg_ssby | input | 1 | Standby select |
| cfg_dton | input | 1 | Direct-transition enable |
| cfg_pss | input | 1 | Watchdog prescaler select |
| cfg_lson | input | 1 | Low-speed-on select for wake target |
| cfg_med | input | 1 | Medium-speed select when low-speed is off |
| cfg_sts | input | 3 | Settling-time code |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 5 | External interrupt lines |
| irq_en | input | 5 | Per-line enables |
| wdt_ovf | input | 1 | Watchdog overflow interrupt request |
| wdt_ovf_en | input | 1 | Watchdog interrupt enable |
| wdt_mask | input | 1 | CPU mask for peripheral interrupts |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| hold_o | output | 1 | State and pin retention hold |
| exc_start | output | 1 | Interrupt exception start pulse |
| exc_src | output | 2 | Wake source of the last exception start |

## Verification
Every output is registered, so the effect of a sleep request, a wake event, a reset or a standby-pin change appears one edge after it is sampled. The bench drives inputs just after a falling edge and checks on the next falling edge. The settling delay is measured by counting falling-edge samples in mode 4, starting with the sample right after the wake edge. That count must equal 2^(8+code) for every one of the eight codes, and `exc_start` is checked on the first sample in mode 0 and again on the sample after it.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    M_HIGH   = 3'd0,
    M_MED    = 3'd1,
    M_SUB    = 3'd2,
    M_WATCH  = 3'd3,
    M_SETTLE = 3'd4,
    M_HWSTBY = 3'd5
  } pmode_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_WDT  = 2'd3
  } wsrc_t;
endpackage

// File: rtl/wpc_wake_arb.sv
module wpc_wake_arb
  import wpc_pkg::*;
#(
  parameter int N_IRQ = 5
) (
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_ovf,
  input  logic             wdt_ovf_en,
  input  logic             wdt_mask,
  output logic             wake,
  output wsrc_t            src
);
  logic [N_IRQ-1:0] irq_live;
  logic             irq_any;
  logic             wdt_live;

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_line
      assign irq_live[gi] = irq[gi] & irq_en[gi];
    end
  endgenerate

  assign irq_any  = |irq_live;
  assign wdt_live = wdt_ovf & wdt_ovf_en & ~wdt_mask;

  always_comb begin
    src = SRC_NONE;
    if (nmi)           src = SRC_NMI;
    else if (irq_any)  src = SRC_IRQ;
    else if (wdt_live) src = SRC_WDT;
  end

  assign wake = nmi | irq_any | wdt_live;
endmodule

// File: rtl/wpc_settle_cnt.sv
module wpc_settle_cnt #(
  parameter int CODE_W   = 3,
  parameter int BASE_EXP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              run,
  output logic              done
);
  localparam int MAX_EXP = BASE_EXP + (1 << CODE_W) - 1;
  localparam int CNT_W   = MAX_EXP;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;

  assign ld_val = (CNT_W'(1) << (CNT_W'(BASE_EXP) + CNT_W'(code))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= ld_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);

  // R7: once expired, the counter never wraps without a fresh load
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/watch_pwr_ctrl.sv
module watch_pwr_ctrl
  import wpc_pkg::*;
#(
  parameter int N_IRQ    = 5,
  parameter int CODE_W   = 3,
  parameter int BASE_EXP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_n,
  input  logic              sleep_req,
  input  logic              cfg_ssby,
  input  logic              cfg_dton,
  input  logic              cfg_pss,
  input  logic              cfg_lson,
  input  logic              cfg_med,
  input  logic [CODE_W-1:0] cfg_sts,
  input  logic              nmi,
  input  logic [N_IRQ-1:0]  irq,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              wdt_ovf,
  input  logic              wdt_ovf_en,
  input  logic              wdt_mask,
  output logic [2:0]        mode_o,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              wdt_clk_en,
  output logic              hold_o,
  output logic              exc_start,
  output logic [1:0]        exc_src
);
  pmode_t mode_q, mode_nx, mode_d;
  wsrc_t  src_q, wake_src;
  logic   wake_any, entry_ok, exc_nx, exc_d, load_nx, settle_done;
  logic   cpu_q, per_q, wdt_q, hold_q, exc_q;

  wpc_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .nmi(nmi), .irq(irq), .irq_en(irq_en), .wdt_ovf(wdt_ovf),
    .wdt_ovf_en(wdt_ovf_en), .wdt_mask(wdt_mask),
    .wake(wake_any), .src(wake_src)
  );

  wpc_settle_cnt #(.CODE_W(CODE_W), .BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst(rst), .load(load_nx & stby_n & ~rst), .code(cfg_sts),
    .run(mode_q == M_SETTLE), .done(settle_done)
  );

  assign entry_ok = sleep_req & cfg_ssby & ~cfg_dton & cfg_pss &
                    (mode_q == M_HIGH || mode_q == M_SUB);

  always_comb begin
    mode_nx = mode_q;
    exc_nx  = 1'b0;
    load_nx = 1'b0;
    unique case (mode_q)
      M_HIGH, M_SUB: if (entry_ok) mode_nx = M_WATCH;
      M_WATCH: begin
        if (wake_any) begin
          if (cfg_lson) begin
            mode_nx = M_SUB;
            exc_nx  = 1'b1;
          end else if (cfg_med) begin
            mode_nx = M_MED;
            exc_nx  = 1'b1;
          end else begin
            mode_nx = M_SETTLE;
            load_nx = 1'b1;
          end
        end
      end
      M_SETTLE: begin
        if (settle_done) begin
          mode_nx = M_HIGH;
          exc_nx  = 1'b1;
        end
      end
      default: mode_nx = mode_q;
    endcase
  end

  always_comb begin
    if (!stby_n)  mode_d = M_HWSTBY;
    else if (rst) mode_d = M_HIGH;
    else          mode_d = mode_nx;
  end
  assign exc_d = exc_nx & stby_n & ~rst;

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
    cpu_q  <= (mode_d == M_HIGH || mode_d == M_MED || mode_d == M_SUB);
    per_q  <= (mode_d == M_HIGH || mode_d == M_MED || mode_d == M_SUB);
    wdt_q  <= (mode_d != M_HWSTBY);
    hold_q <= (mode_d == M_WATCH || mode_d == M_SETTLE);
    exc_q  <= exc_d;
    if (rst && stby_n) src_q <= SRC_NONE;
    else if (exc_d)    src_q <= (mode_q == M_SETTLE) ? src_q : wake_src;
    else if (load_nx && stby_n) src_q <= wake_src;
  end

  assign mode_o     = mode_q;
  assign cpu_clk_en = cpu_q;
  assign per_clk_en = per_q;
  assign wdt_clk_en = wdt_q;
  assign hold_o     = hold_q;
  assign exc_start  = exc_q;
  assign exc_src    = src_q;

  // R4: watch gates CPU and peripherals, keeps watchdog, holds state
  p_watch_gates_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_WATCH) |-> (!cpu_clk_en && !per_clk_en && wdt_clk_en && hold_o));

  // R7: settling keeps the core stopped and state held
  p_settle_gates_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SETTLE) |-> (hold_o && !cpu_clk_en && !per_clk_en));

  // R3: a sleep request with bad configuration leaves the mode alone
  p_sleep_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (stby_n && sleep_req && !(cfg_ssby && !cfg_dton && cfg_pss) &&
     mode_q != M_WATCH && mode_q != M_SETTLE)
    |=> (mode_q == $past(mode_q) || mode_q == M_HWSTBY));

  // R9: exception start lasts one cycle
  p_exc_once_r9: assert property (@(posedge clk) disable iff (rst)
    exc_start |=> !exc_start);

  // R9: exception start only follows watch or settling
  p_exc_after_wake_r9: assert property (@(posedge clk) disable iff (rst)
    exc_start |-> ($past(mode_q) == M_WATCH || $past(mode_q) == M_SETTLE));

  // R10: standby pin low shuts every clock
  p_hwstby_r10: assert property (@(posedge clk) disable iff (rst)
    !stby_n |=> (mode_q == M_HWSTBY && !wdt_clk_en && !cpu_clk_en && !per_clk_en));
endmodule

// File: tb/test_watch_pwr_ctrl.sv
module test_watch_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst, stby_n, sleep_req, cfg_ssby, cfg_dton, cfg_pss, cfg_lson, cfg_med;
  logic [2:0] cfg_sts;
  logic       nmi, wdt_ovf, wdt_ovf_en, wdt_mask;
  logic [4:0] irq, irq_en;
  logic [2:0] mode_o;
  logic       cpu_clk_en, per_clk_en, wdt_clk_en, hold_o, exc_start;
  logic [1:0] exc_src;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  watch_pwr_ctrl i_watch_pwr_ctrl (
    .clk(clk), .rst(rst), .stby_n(stby_n), .sleep_req(sleep_req),
    .cfg_ssby(cfg_ssby), .cfg_dton(cfg_dton), .cfg_pss(cfg_pss),
    .cfg_lson(cfg_lson), .cfg_med(cfg_med), .cfg_sts(cfg_sts),
    .nmi(nmi), .irq(irq), .irq_en(irq_en), .wdt_ovf(wdt_ovf),
    .wdt_ovf_en(wdt_ovf_en), .wdt_mask(wdt_mask),
    .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .wdt_clk_en(wdt_clk_en), .hold_o(hold_o), .exc_start(exc_start),
    .exc_src(exc_src)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    stby_n = 1'b1; sleep_req = 1'b0; cfg_ssby = 1'b0; cfg_dton = 1'b0;
    cfg_pss = 1'b0; cfg_lson = 1'b0; cfg_med = 1'b0; cfg_sts = 3'd0;
    nmi = 1'b0; irq = '0; irq_en = '0; wdt_ovf = 1'b0; wdt_ovf_en = 1'b0;
    wdt_mask = 1'b0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  task automatic enter_watch();
    cfg_ssby = 1'b1; cfg_dton = 1'b0; cfg_pss = 1'b1; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic nmi_wake(input logic lson, input logic med);
    cfg_lson = lson; cfg_med = med; nmi = 1'b1;
    tick();
    nmi = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst = 1'b1;
    tick();

    // R1: reset state
    do_reset();
    chk("R1 mode", mode_o, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 per", per_clk_en, 1);
    chk("R1 wdt", wdt_clk_en, 1);
    chk("R1 hold", hold_o, 0);
    chk("R1 exc", exc_start, 0);

    // R2/R3: sweep start mode x configuration bits
    for (int sm = 0; sm < 3; sm++) begin
      for (int c = 0; c < 8; c++) begin
        int start_mode;
        int exp_mode;
        do_reset();
        start_mode = 0;
        if (sm == 1) begin enter_watch(); nmi_wake(1'b1, 1'b0); start_mode = 2; end
        if (sm == 2) begin enter_watch(); nmi_wake(1'b0, 1'b1); start_mode = 1; end
        chk("R6 reach", mode_o, start_mode);
        cfg_ssby = c[0]; cfg_dton = c[1]; cfg_pss = c[2]; sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        exp_mode = (start_mode != 1 && c[0] && !c[1] && c[2]) ? 3 : start_mode;
        if (exp_mode == 3) begin
          chk("R2 enter", mode_o, 3);
          // R4: gating in watch
          chk("R4 cpu", cpu_clk_en, 0);
          chk("R4 per", per_clk_en, 0);
          chk("R4 wdt", wdt_clk_en, 1);
          chk("R4 hold", hold_o, 1);
        end else begin
          chk("R3 ignored", mode_o, exp_mode);
        end
      end
    end

    // R5: each external line with enable off and on
    for (int ln = 0; ln < 5; ln++) begin
      for (int en = 0; en < 2; en++) begin
        do_reset();
        enter_watch();
        cfg_lson = 1'b1;
        irq = 5'(1 << ln);
        irq_en = en[0] ? 5'(1 << ln) : ~5'(1 << ln);
        tick();
        irq = '0;
        chk("R5 irq mode", mode_o, en[0] ? 2 : 3);
        chk("R5 irq exc", exc_start, en[0] ? 1 : 0);
        if (en[0]) chk("R9 src irq", exc_src, 2);
      end
    end

    // R5: watchdog overflow with enable and mask combinations
    for (int k = 0; k < 4; k++) begin
      bit woke;
      do_reset();
      enter_watch();
      cfg_lson = 1'b1;
      wdt_ovf_en = k[0]; wdt_mask = k[1]; wdt_ovf = 1'b1;
      tick();
      wdt_ovf = 1'b0;
      woke = k[0] && !k[1];
      chk("R5 wdt mode", mode_o, woke ? 2 : 3);
      chk("R5 wdt exc", exc_start, woke ? 1 : 0);
      if (woke) chk("R9 src wdt", exc_src, 3);
    end

    // R6: medium target, exc pulse once
    do_reset();
    enter_watch();
    nmi_wake(1'b0, 1'b1);
    chk("R6 med mode", mode_o, 1);
    chk("R6 med exc", exc_start, 1);
    chk("R6 med cpu", cpu_clk_en, 1);
    tick();
    chk("R9 single pulse", exc_start, 0);

    // R9: priority
    do_reset();
    enter_watch();
    cfg_lson = 1'b1; nmi = 1'b1; irq = 5'b11111; irq_en = 5'b11111;
    wdt_ovf = 1'b1; wdt_ovf_en = 1'b1;
    tick();
    nmi = 1'b0; irq = '0; wdt_ovf = 1'b0;
    chk("R9 nmi first", exc_src, 1);
    do_reset();
    enter_watch();
    cfg_lson = 1'b1; irq = 5'b00100; irq_en = 5'b00100;
    wdt_ovf = 1'b1; wdt_ovf_en = 1'b1;
    tick();
    irq = '0; wdt_ovf = 1'b0;
    chk("R9 irq over wdt", exc_src, 2);

    // R7/R8: settling length for every code
    for (int code = 0; code < 8; code++) begin
      int cyc;
      do_reset();
      enter_watch();
      cfg_sts = 3'(code);
      nmi_wake(1'b0, 1'b0);
      cfg_sts = 3'(7 - code);
      chk("R7 settle mode", mode_o, 4);
      chk("R7 settle hold", hold_o, 1);
      chk("R7 settle cpu", cpu_clk_en, 0);
      chk("R7 settle exc", exc_start, 0);
      cyc = 0;
      while (mode_o == 3'd4 && cyc < 40000) begin
        cyc++;
        tick();
      end
      chk("R8 settle length", cyc, 1 << (8 + code));
      chk("R7 high after", mode_o, 0);
      chk("R7 exc", exc_start, 1);
      chk("R9 src nmi", exc_src, 1);
      tick();
      chk("R9 single pulse", exc_start, 0);
    end

    // R10: standby from watch, settling and high-speed, over reset
    for (int s = 0; s < 3; s++) begin
      do_reset();
      if (s >= 1) enter_watch();
      if (s == 2) nmi_wake(1'b0, 1'b0);
      stby_n = 1'b0; rst = 1'b1;
      tick();
      chk("R10 mode", mode_o, 5);
      chk("R10 cpu", cpu_clk_en, 0);
      chk("R10 per", per_clk_en, 0);
      chk("R10 wdt", wdt_clk_en, 0);
      rst = 1'b0; stby_n = 1'b1; nmi = 1'b1;
      tick();
      nmi = 1'b0;
      chk("R10 stays", mode_o, 5);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk("R10 exit by reset", mode_o, 0);
    end

    // R11: reset beats a same-cycle wake
    do_reset();
    enter_watch();
    cfg_lson = 1'b1; nmi = 1'b1; rst = 1'b1;
    tick();
    nmi = 1'b0; rst = 1'b0;
    chk("R11 mode", mode_o, 0);
    chk("R11 exc", exc_start, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule